// File: doc/BRIEF.md
# Time-Slot Channel Gatherer

The block sits after frame alignment and phase correction in a time-division receive chain. Each frame's data field carries 96 time slots, each 16 kbit/s wide. Every slot holds a fixed number of bits per frame, and the slots follow one another in index order. A group of up to eight slots makes up one broadcast channel. The block receives the data field one bit per accepted cycle. It gathers the bits of the slots chosen by the controller and emits them as one byte stream for that broadcast channel.

The controller writes up to eight slot indices and a count into shadow registers, then pulses an apply strobe. The shadow set becomes active only at the start of the next locked data field, so a frame is never split across two selections. Within a frame, each selected slot is buffered whole. At the end of the field the slots are emitted in the order of their selection entries, not in their order on the line. Each byte is output MSB first. A start-of-frame flag marks the first byte of each frame. If frame lock drops partway through a field, that frame yields no output.

Top module: `slot_gatherer`

## Requirements
- R1: After reset all outputs are low, both shadow and active counts are 0, and a frame produces no bytes until a selection has been applied.
- R2: A write with `cfgSel` 0 to 7 loads the 7-bit slot index of that selection entry. A write with `cfgSel` equal to 8 loads the 4-bit count from the low bits of `cfgWrData`. A count above 8 acts as 8.
- R3: An entry at a position equal to or above the count, or holding an index of 96 or more, is unused. It yields no bytes, and later entries close up behind it. A frame never yields more than 8 slots' worth of bytes.
- R4: `cfgApply` arms a pending flag. On the first locked data-field bit in a later cycle, the shadow set is copied to the active set and governs that frame. An apply in the same cycle as a field start waits for the following frame. Shadow writes without an apply leave the active selection unchanged.
- R5: A data field begins with the accepted bit flagged `fieldStart` (with `frameLock` high) and holds 96×8 accepted bits. Slot s occupies bits 8s to 8s+7. Cycles with `symValid` low are skipped. No byte appears before a field has begun.
- R6: After the edge that accepts the last bit of a field, the frame's bytes appear one per cycle, with no gaps, starting on the next edge. The order is the first used entry's slot first. Each slot's bits are in arrival order, and the first bit of each byte is its MSB.
- R7: `bcSof` is high exactly on the first byte of each frame, and only together with `bcValid`.
- R8: `frameLock` low during a field drops that frame entirely. Output resumes with the next field that starts and stays locked.
- R9: Frames may follow back to back. Output from one frame overlaps capture of the next without losing or corrupting either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Selection register write enable |
| cfgSel | input | 4 | Register select: 0-7 slot entries, 8 count |
| cfgWrData | input | 7 | Write data (slot index, or count in low 4 bits) |
| cfgApply | input | 1 | Apply strobe for the shadow selection |
| symValid | input | 1 | A data-field bit is present this cycle |
| symBit | input | 1 | Data-field bit |
| fieldStart | input | 1 | Marks the first bit of a data field |
| frameLock | input | 1 | Frame alignment held |
| bcByte | output | 8 | Broadcast-channel byte |
| bcValid | output | 1 | `bcByte` is valid |
| bcSof | output | 1 | First byte of a frame |

## Verification
The apply strobe and a field start can land in the same cycle, and so can a shadow write. The bench drives `cfgApply` on the very bit flagged `fieldStart` after loading a new count. It expects that frame to keep the old selection and the next frame to use the new one. Two functions also overlap: the output of one frame and the capture of the next. Frames are sent back to back with random idle bits so that draining and capture share cycles. A behavioural model compares every output on every clock, and byte and start-of-frame totals are checked per frame.

// File: rtl/slot_gatherer_pkg.sv
package slot_gatherer_pkg;
  localparam int NSEL           = 8;
  localparam int NSLOT          = 96;
  localparam int SLOT_BITS      = 8;
  localparam int IDXW           = $clog2(NSLOT + 1);
  localparam int CNTW           = $clog2(NSEL + 1);
  localparam int SELW           = CNTW;
  localparam int RANKW          = $clog2(NSEL);
  localparam int BITW           = $clog2(SLOT_BITS);
  localparam int BYTES_PER_SLOT = SLOT_BITS / 8;
  localparam int BANKW          = NSEL * SLOT_BITS;
  localparam int MAXBYTES       = NSEL * BYTES_PER_SLOT;
  localparam int BYTEW          = $clog2(MAXBYTES + 1);

  typedef struct packed {
    logic            capEn;
    logic            capBit;
    logic [NSEL-1:0] rankHit;
    logic [BITW-1:0] bitIdx;
    logic            frameDone;
    logic [CNTW-1:0] usedCnt;
  } strobe_t;
endpackage

// File: rtl/slot_gatherer_ctrl.sv
module slot_gatherer_ctrl
  import slot_gatherer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgWrEn,
  input  logic [SELW-1:0] cfgSel,
  input  logic [IDXW-1:0] cfgWrData,
  input  logic            cfgApply,
  input  logic            symValid,
  input  logic            symBit,
  input  logic            fieldStart,
  input  logic            frameLock,
  output strobe_t         stb
);
  logic [IDXW-1:0] shadowIdx [NSEL];
  logic [IDXW-1:0] activeIdx [NSEL];
  logic [IDXW-1:0] effIdx    [NSEL];
  logic [CNTW-1:0] shadowCnt, activeCnt, effCnt, effCntC;
  logic            pending, inFrame;
  logic [IDXW-1:0] slotCnt, curSlot;
  logic [BITW-1:0] bitCnt, curBit;
  logic [NSEL-1:0] used, hit;
  logic [CNTW-1:0] nUsed;
  logic            startNow, applyNow, capEn, lastBit;

  assign startNow = symValid & fieldStart & frameLock;
  assign applyNow = startNow & pending;
  assign effCnt   = applyNow ? shadowCnt : activeCnt;
  assign effCntC  = (effCnt > CNTW'(NSEL)) ? CNTW'(NSEL) : effCnt;
  assign curSlot  = startNow ? '0 : slotCnt;
  assign curBit   = startNow ? '0 : bitCnt;
  assign capEn    = symValid & frameLock & (startNow | inFrame);
  assign lastBit  = capEn && (curSlot == IDXW'(NSLOT - 1)) && (curBit == BITW'(SLOT_BITS - 1));

  for (genvar e = 0; e < NSEL; e++) begin : g_entry
    assign effIdx[e] = applyNow ? shadowIdx[e] : activeIdx[e];
    assign used[e]   = (CNTW'(e) < effCntC) && (effIdx[e] < IDXW'(NSLOT));
  end

  // compaction: used entries take consecutive ranks in entry order
  always_comb begin
    logic [RANKW-1:0] rk;
    rk    = '0;
    nUsed = '0;
    hit   = '0;
    for (int e = 0; e < NSEL; e++) begin
      if (used[e]) begin
        if (effIdx[e] == curSlot) hit[rk] = 1'b1;
        rk    = rk + 1'b1;
        nUsed = nUsed + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NSEL; e++) begin
        shadowIdx[e] <= '0;
        activeIdx[e] <= '0;
      end
      shadowCnt <= '0;
      activeCnt <= '0;
      pending   <= 1'b0;
    end else begin
      if (applyNow) begin
        for (int e = 0; e < NSEL; e++) activeIdx[e] <= shadowIdx[e];
        activeCnt <= shadowCnt;
      end
      if (cfgWrEn) begin
        if (cfgSel < SELW'(NSEL)) shadowIdx[cfgSel[RANKW-1:0]] <= cfgWrData;
        else if (cfgSel == SELW'(NSEL)) shadowCnt <= cfgWrData[CNTW-1:0];
      end
      pending <= cfgApply | (pending & ~applyNow);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFrame <= 1'b0;
      slotCnt <= '0;
      bitCnt  <= '0;
    end else if (!frameLock) begin
      inFrame <= 1'b0;
    end else if (capEn) begin
      inFrame <= !lastBit;
      if (curBit == BITW'(SLOT_BITS - 1)) begin
        bitCnt  <= '0;
        slotCnt <= curSlot + 1'b1;
      end else begin
        bitCnt  <= curBit + 1'b1;
        slotCnt <= curSlot;
      end
    end
  end

  assign stb.capEn     = capEn;
  assign stb.capBit    = symBit;
  assign stb.rankHit   = hit;
  assign stb.bitIdx    = curBit;
  assign stb.frameDone = lastBit;
  assign stb.usedCnt   = nUsed;
endmodule

// File: rtl/slot_gatherer_dp.sv
module slot_gatherer_dp
  import slot_gatherer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    stb,
  output logic [7:0] bcByte,
  output logic       bcValid,
  output logic       bcSof
);
  logic [BANKW-1:0] bank [2];
  logic             wrSel, rdSel;
  logic [BYTEW-1:0] drainLeft, drainPtr;
  logic [BANKW-1:0] rdVec;
  logic [7:0]       slice, curByte;

  // capture: each rank owns SLOT_BITS positions in the write bank
  always_ff @(posedge clk) begin
    if (stb.capEn) begin
      for (int r = 0; r < NSEL; r++) begin
        if (stb.rankHit[r]) bank[wrSel][r*SLOT_BITS + int'(stb.bitIdx)] <= stb.capBit;
      end
    end
  end

  assign rdVec = bank[rdSel];

  always_comb begin
    slice = rdVec[int'(drainPtr)*8 +: 8];
    for (int j = 0; j < 8; j++) curByte[7-j] = slice[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrSel     <= 1'b0;
      rdSel     <= 1'b1;
      drainLeft <= '0;
      drainPtr  <= '0;
    end else if (stb.frameDone) begin
      wrSel     <= ~wrSel;
      rdSel     <= wrSel;
      drainLeft <= BYTEW'(stb.usedCnt) * BYTEW'(BYTES_PER_SLOT);
      drainPtr  <= '0;
    end else if (drainLeft != '0) begin
      drainLeft <= drainLeft - 1'b1;
      drainPtr  <= drainPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcValid <= 1'b0;
      bcSof   <= 1'b0;
      bcByte  <= '0;
    end else begin
      bcValid <= (drainLeft != '0);
      bcSof   <= (drainLeft != '0) && (drainPtr == '0);
      if (drainLeft != '0) bcByte <= curByte;
    end
  end
endmodule

// File: rtl/slot_gatherer.sv
module slot_gatherer
  import slot_gatherer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgWrEn,
  input  logic [SELW-1:0] cfgSel,
  input  logic [IDXW-1:0] cfgWrData,
  input  logic            cfgApply,
  input  logic            symValid,
  input  logic            symBit,
  input  logic            fieldStart,
  input  logic            frameLock,
  output logic [7:0]      bcByte,
  output logic            bcValid,
  output logic            bcSof
);
  strobe_t stb;

  slot_gatherer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgApply(cfgApply), .symValid(symValid),
    .symBit(symBit), .fieldStart(fieldStart), .frameLock(frameLock), .stb(stb)
  );

  slot_gatherer_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .bcByte(bcByte), .bcValid(bcValid), .bcSof(bcSof)
  );
endmodule

// File: rtl/slot_gatherer_chk.sv
module slot_gatherer_chk
  import slot_gatherer_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic symValid,
  input logic fieldStart,
  input logic frameLock,
  input logic bcValid,
  input logic bcSof
);
  logic             seenStart;
  logic [BYTEW-1:0] byteRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenStart <= 1'b0;
      byteRun   <= '0;
    end else begin
      if (symValid && fieldStart && frameLock) seenStart <= 1'b1;
      if (bcValid) byteRun <= bcSof ? BYTEW'(1) : byteRun + 1'b1;
    end
  end

  // R6
  contiguous_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcValid && !bcSof) |-> $past(bcValid));

  // R7
  sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcSof |-> bcValid);

  // R3
  byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcValid && !bcSof) |-> (byteRun < BYTEW'(MAXBYTES)));

  // R5
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcValid |-> seenStart);
endmodule

bind slot_gatherer slot_gatherer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .symValid(symValid), .fieldStart(fieldStart),
  .frameLock(frameLock), .bcValid(bcValid), .bcSof(bcSof)
);

// File: tb/slot_gatherer_test.sv
`timescale 1ns/1ps
module slot_gatherer_test;
  import slot_gatherer_pkg::*;
  localparam int FRAME_BITS = NSLOT * SLOT_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfgWrEn = 1'b0, cfgApply = 1'b0;
  logic [SELW-1:0] cfgSel = '0;
  logic [IDXW-1:0] cfgWrData = '0;
  logic symValid = 1'b0, symBit = 1'b0, fieldStart = 1'b0, frameLock = 1'b0;
  logic [7:0] bcByte;
  logic bcValid, bcSof;

  int checks = 0, fails = 0;
  int dutBytes = 0, dutSofs = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slot_gatherer uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgApply(cfgApply), .symValid(symValid),
    .symBit(symBit), .fieldStart(fieldStart), .frameLock(frameLock),
    .bcByte(bcByte), .bcValid(bcValid), .bcSof(bcSof)
  );

  // behavioural reference model
  int mShadow [NSEL];
  int mActive [NSEL];
  int mShCnt, mActCnt, mPos;
  bit mPending, mIn;
  bit mFrame [FRAME_BITS];
  logic [7:0] outQ [$];
  bit sofQ [$];
  bit mValid, mSof;
  logic [7:0] mByte;

  task automatic emit();
    bit bits [$];
    int n;
    n = (mActCnt > NSEL) ? NSEL : mActCnt;
    for (int e = 0; e < n; e++)
      if (mActive[e] < NSLOT)
        for (int b = 0; b < SLOT_BITS; b++) bits.push_back(mFrame[mActive[e]*SLOT_BITS + b]);
    for (int k = 0; k < bits.size() / 8; k++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[7-j] = bits[k*8 + j];
      outQ.push_back(v);
      sofQ.push_back(k == 0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NSEL; e++) begin mShadow[e] = 0; mActive[e] = 0; end
      mShCnt = 0; mActCnt = 0; mPending = 0; mIn = 0; mPos = 0;
      outQ.delete(); sofQ.delete();
      mValid = 0; mSof = 0; mByte = '0;
    end else begin
      bit start, applyNow;
      start    = symValid && fieldStart && frameLock;
      applyNow = start && mPending;
      if (outQ.size() > 0) begin
        mValid = 1; mByte = outQ.pop_front(); mSof = sofQ.pop_front();
      end else begin
        mValid = 0; mSof = 0;
      end
      if (applyNow) begin
        for (int e = 0; e < NSEL; e++) mActive[e] = mShadow[e];
        mActCnt = mShCnt;
      end
      if (cfgWrEn) begin
        if (int'(cfgSel) < NSEL) mShadow[cfgSel] = int'(cfgWrData);
        else if (int'(cfgSel) == NSEL) mShCnt = int'(cfgWrData) % (1 << CNTW);
      end
      mPending = cfgApply || (mPending && !applyNow);
      if (!frameLock) mIn = 0;
      else if (symValid && (start || mIn)) begin
        if (start) mPos = 0;
        mFrame[mPos] = symBit;
        if (mPos == FRAME_BITS - 1) begin
          emit();
          mIn = 0;
        end else begin
          mIn = 1;
          mPos++;
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (bcValid !== mValid || bcSof !== mSof || (mValid && bcByte !== mByte)) begin
        fails++;
        $display("FAIL R6 stream: act v=%0b s=%0b d=%02h exp v=%0b s=%0b d=%02h",
                 bcValid, bcSof, bcByte, mValid, mSof, mByte);
      end
      if (bcValid === 1'b1) dutBytes++;
      if (bcSof === 1'b1) dutSofs++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      symValid = 0; fieldStart = 0; cfgWrEn = 0; cfgApply = 0; frameLock = 1;
    end
  endtask

  task automatic wr(int sel, int d);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = SELW'(sel); cfgWrData = IDXW'(d);
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic apply();
    @(negedge clk); cfgApply = 1;
    @(negedge clk); cfgApply = 0;
  endtask

  task automatic frame(int dropAt, bit gaps, bit applyAtStart);
    for (int p = 0; p < FRAME_BITS; p++) begin
      if (gaps && ($urandom % 5 == 0)) begin
        @(negedge clk);
        symValid = 0; fieldStart = 0; cfgApply = 0;
      end
      @(negedge clk);
      symValid   = 1;
      symBit     = $urandom % 2;
      fieldStart = (p == 0);
      frameLock  = (p != dropAt);
      cfgApply   = applyAtStart && (p == 0);
    end
    @(negedge clk);
    symValid = 0; fieldStart = 0; cfgApply = 0; frameLock = 1;
  endtask

  task automatic measure(int nFrames, int dropAt, bit gaps, bit applyFirst,
                         string req, int expBytes, int expSofs);
    int b0, s0;
    b0 = dutBytes; s0 = dutSofs;
    for (int f = 0; f < nFrames; f++) frame(f == 0 ? dropAt : -1, gaps, applyFirst && f == 0);
    idle(20);
    chk({req, " bytes"}, dutBytes - b0, expBytes);
    chk({req, " sofs"}, dutSofs - s0, expSofs);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: act timeout exp completion");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; frameLock = 1;
    @(negedge clk);
    // R1: reset state and no output without a selection
    chk("R1 valid", int'(bcValid), 0);
    chk("R1 sof", int'(bcSof), 0);
    measure(1, -1, 0, 0, "R1 unconfigured", 0, 0);

    // R2 R6: four slots in a shuffled order
    wr(0, 5); wr(1, 0); wr(2, 95); wr(3, 17); wr(8, 4); apply();
    measure(1, -1, 0, 0, "R2 four slots", 4, 1);

    // R3: index 100 is unused and later entries close up
    wr(1, 100); wr(8, 3); apply();
    measure(1, -1, 0, 0, "R3 unused index", 2, 1);

    // R2 clamp and R9 back-to-back frames with gaps (R5)
    for (int e = 0; e < NSEL; e++) wr(e, (e * 13 + 2) % NSLOT);
    wr(5, 2); wr(8, 12); apply();
    measure(2, -1, 1, 0, "R9 back-to-back clamp", 16, 2);

    // R8: lock loss drops the frame, next frame recovers
    measure(1, 300, 0, 0, "R8 dropped", 0, 0);
    measure(1, -1, 0, 0, "R8 resumed", 8, 1);

    // R4: apply in the same cycle as a field start waits one frame
    wr(8, 1);
    measure(1, -1, 0, 1, "R4 same-cycle apply", 8, 1);
    measure(1, -1, 0, 0, "R4 applied next frame", 1, 1);

    // R4: shadow write without apply has no effect
    wr(8, 2);
    measure(1, -1, 1, 0, "R4 no apply", 1, 1);

    // R3: count zero yields nothing
    wr(8, 0); apply();
    measure(1, -1, 0, 0, "R3 count zero", 0, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule